// File: doc/BRIEF.md
# Dual-Input Scaled Feedback Datapath

This block forms one output sample from two signed input streams for a closed-loop control experiment. Each channel is multiplied by its own 5-bit scale factor. The second channel first passes through a delay line whose length can be programmed. In single mode only the first channel reaches the output, and the polarity setting can invert it. In dual mode the two scaled channels are added together, or the second is subtracted from the first when negative feedback is selected. Every arithmetic step saturates instead of wrapping.

Samples arrive with a valid strobe, and the result leaves with its own valid strobe a fixed number of cycles later. The configuration inputs are sampled in the same cycle as the sample they apply to. They then travel through the pipeline with that sample, so a setting that changes mid-stream never affects a sample already inside. Four peak-magnitude registers record the largest magnitude seen since the last clear. They watch the raw channel 1 input, the raw channel 2 input, the scaled values and the final result.

Top module: `fbk_datapath`

## Requirements
- R1: `valid_o` rises exactly three clock edges after the edge that captures `valid_i`, and is low otherwise. One sample is accepted per valid cycle.
- R2: A scaled value is floor(x·f/16), where x is the 12-bit signed sample and f is the 5-bit unsigned factor, so f=16 is unity. The value is then clamped to the range −2048..2047.
- R3: With `dual_mode_i`=0 and `neg_fb_i`=0, `out_o` equals scaled channel 1, and `in2_i` has no effect on `out_o`.
- R4: With `dual_mode_i`=0 and `neg_fb_i`=1, `out_o` equals the negated scaled channel 1. Negating −2048 gives 2047.
- R5: With `dual_mode_i`=1, `out_o` is scaled1 + scaled2 when `neg_fb_i`=0 and scaled1 − scaled2 when `neg_fb_i`=1. The result clamps to 2047 or −2048.
- R6: Channel 2 is taken from the valid sample that came d valid samples earlier, where d is `delay_i`. With d=0 the current sample is used. Channel 1 is never delayed.
- R7: Mode, polarity, scale factors and delay are sampled in the cycle where `valid_i` is high. Changing them in later cycles does not alter that sample's result.
- R8: A new `delay_i` value applies to the very next valid sample, with no reset needed.
- R9: `pk_in1_o`, `pk_in2_o`, `pk_scale_o` and `pk_out_o` hold the largest magnitude seen since the last clear. They track raw in1, raw (undelayed) in2, the larger of the two scaled magnitudes, and `out_o` respectively. The magnitude of −2048 is 2048.
- R10: A high `clr_peaks_i` zeroes all four peak registers at the next edge. The clear takes priority over any update in that same cycle.
- R11: While `rst_ni` is low, `valid_o`, `out_o` and all peaks are zero. After reset, every delayed entry that has not yet been written reads as zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| valid_i | input | 1 | Input sample strobe |
| in1_i | input | 12 | Channel 1 sample, two's complement |
| in2_i | input | 12 | Channel 2 sample, two's complement |
| dual_mode_i | input | 1 | 0 = single (channel 1 only), 1 = dual |
| neg_fb_i | input | 1 | 1 = negative feedback |
| scale1_i | input | 5 | Channel 1 factor, 16 = unity |
| scale2_i | input | 5 | Channel 2 factor, 16 = unity |
| delay_i | input | 8 | Channel 2 delay in samples |
| clr_peaks_i | input | 1 | Synchronous clear of peak registers |
| valid_o | output | 1 | Output sample strobe |
| out_o | output | 12 | Result sample, two's complement |
| pk_in1_o | output | 12 | Peak magnitude of channel 1 input |
| pk_in2_o | output | 12 | Peak magnitude of channel 2 input |
| pk_scale_o | output | 12 | Peak magnitude of scaled values |
| pk_out_o | output | 12 | Peak magnitude of output |

## Verification
The hardest case to reach is a configuration change that lands while a sample is already in the pipeline, followed by a delay read from history that has wrapped or was cleared by reset. To reach it, the bench inverts every configuration input in the cycle right after each valid strobe. It sweeps the delay through 0, 1, 3 and 255 across several thousand samples, so the circular buffer wraps many times. It also applies a reset in the middle of the run and then reads delayed entries that were never written. The expected value of every sample comes from an integer model that keeps its own history of channel 2.

// File: rtl/fbk_pkg.sv
`timescale 1ns/1ps
package fbk_pkg;
  typedef enum logic {MODE_SINGLE = 1'b0, MODE_DUAL = 1'b1} mode_e;
  typedef enum logic {POL_POS = 1'b0, POL_NEG = 1'b1} pol_e;
endpackage

// File: rtl/fbk_delay.sv
`timescale 1ns/1ps
// Circular sample history; DEPTH must be a power of two.
module fbk_delay #(
  parameter int DW    = 12,
  parameter int DEPTH = 256,
  localparam int AW   = $clog2(DEPTH)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          wr_i,
  input  logic [DW-1:0] din_i,
  input  logic [AW-1:0] dly_i,
  output logic [DW-1:0] dout_o
);
  logic [DW-1:0] mem_q [DEPTH];
  logic [AW-1:0] wptr_q;
  logic [AW-1:0] rd_idx;

  assign rd_idx = wptr_q - dly_i;
  assign dout_o = (dly_i == '0) ? din_i : mem_q[rd_idx];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wptr_q <= '0;
      for (int i = 0; i < DEPTH; i++) mem_q[i] <= '0;
    end else if (wr_i) begin
      mem_q[wptr_q] <= din_i;
      wptr_q        <= wptr_q + 1'b1;
    end
  end
endmodule

// File: rtl/fbk_scale.sv
`timescale 1ns/1ps
// x * f / 2^(SW-1), floor, clamped to DW bits
module fbk_scale #(
  parameter int DW = 12,
  parameter int SW = 5,
  localparam int PW = DW + SW + 1
) (
  input  logic signed [DW-1:0] x_i,
  input  logic        [SW-1:0] f_i,
  output logic signed [DW-1:0] y_o
);
  localparam logic signed [PW-1:0] MAXV = {{(PW-DW+1){1'b0}}, {(DW-1){1'b1}}};
  localparam logic signed [PW-1:0] MINV = ~MAXV;

  logic signed [PW-1:0] prod;
  logic signed [PW-1:0] shifted;

  assign prod    = x_i * $signed({1'b0, f_i});
  assign shifted = prod >>> (SW - 1);

  always_comb begin
    if (shifted > MAXV)      y_o = MAXV[DW-1:0];
    else if (shifted < MINV) y_o = MINV[DW-1:0];
    else                     y_o = shifted[DW-1:0];
  end
endmodule

// File: rtl/fbk_combine.sv
`timescale 1ns/1ps
module fbk_combine
  import fbk_pkg::*;
#(
  parameter int DW = 12
) (
  input  mode_e              mode_i,
  input  pol_e               pol_i,
  input  logic signed [DW-1:0] a_i,
  input  logic signed [DW-1:0] b_i,
  output logic signed [DW-1:0] y_o
);
  localparam logic signed [DW-1:0] MAXV = {1'b0, {(DW-1){1'b1}}};
  localparam logic signed [DW-1:0] MINV = {1'b1, {(DW-1){1'b0}}};

  logic signed [DW:0] ea, eb, r;

  assign ea = {a_i[DW-1], a_i};
  assign eb = {b_i[DW-1], b_i};

  always_comb begin
    unique case ({mode_i, pol_i})
      {MODE_SINGLE, POL_POS}: r = ea;
      {MODE_SINGLE, POL_NEG}: r = -ea;
      {MODE_DUAL,   POL_POS}: r = ea + eb;
      default:                r = ea - eb;
    endcase
    // one guard bit: disagreement with sign means out of range
    if (r[DW] != r[DW-1]) y_o = r[DW] ? MINV : MAXV;
    else                  y_o = r[DW-1:0];
  end
endmodule

// File: rtl/fbk_peak.sv
`timescale 1ns/1ps
module fbk_peak #(
  parameter int DW = 12
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          clr_i,
  input  logic          vld_i,
  input  logic [DW-1:0] mag_i,
  output logic [DW-1:0] pk_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                   pk_o <= '0;
    else if (clr_i)                pk_o <= '0;
    else if (vld_i && mag_i > pk_o) pk_o <= mag_i;
  end
endmodule

// File: rtl/fbk_datapath.sv
`timescale 1ns/1ps
module fbk_datapath
  import fbk_pkg::*;
#(
  parameter int DW    = 12,
  parameter int SW    = 5,
  parameter int DEPTH = 256,
  localparam int AW   = $clog2(DEPTH),
  localparam int NPK  = 4,
  localparam int NCH  = 2
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          valid_i,
  input  logic [DW-1:0] in1_i,
  input  logic [DW-1:0] in2_i,
  input  logic          dual_mode_i,
  input  logic          neg_fb_i,
  input  logic [SW-1:0] scale1_i,
  input  logic [SW-1:0] scale2_i,
  input  logic [AW-1:0] delay_i,
  input  logic          clr_peaks_i,
  output logic          valid_o,
  output logic [DW-1:0] out_o,
  output logic [DW-1:0] pk_in1_o,
  output logic [DW-1:0] pk_in2_o,
  output logic [DW-1:0] pk_scale_o,
  output logic [DW-1:0] pk_out_o
);
  function automatic logic [DW-1:0] mag_f(logic [DW-1:0] v);
    return v[DW-1] ? (~v + {{(DW-1){1'b0}}, 1'b1}) : v;
  endfunction

  // stage 1: capture sample, delayed ch2 and config
  logic                 s1_vld;
  logic signed [DW-1:0] s1_in1, s1_in2d;
  logic        [DW-1:0] s1_in2raw;
  mode_e                s1_mode;
  pol_e                 s1_pol;
  logic        [SW-1:0] s1_f [NCH];
  logic        [DW-1:0] dly_out;

  fbk_delay #(.DW(DW), .DEPTH(DEPTH)) u_delay (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .wr_i   (valid_i),
    .din_i  (in2_i),
    .dly_i  (delay_i),
    .dout_o (dly_out)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      s1_vld    <= 1'b0;
      s1_in1    <= '0;
      s1_in2d   <= '0;
      s1_in2raw <= '0;
      s1_mode   <= MODE_SINGLE;
      s1_pol    <= POL_POS;
      s1_f[0]   <= '0;
      s1_f[1]   <= '0;
    end else begin
      s1_vld <= valid_i;
      if (valid_i) begin
        s1_in1    <= in1_i;
        s1_in2d   <= dly_out;
        s1_in2raw <= in2_i;
        s1_mode   <= mode_e'(dual_mode_i);
        s1_pol    <= pol_e'(neg_fb_i);
        s1_f[0]   <= scale1_i;
        s1_f[1]   <= scale2_i;
      end
    end
  end

  // stage 2: per-channel scaling
  logic signed [DW-1:0] sc_in  [NCH];
  logic signed [DW-1:0] sc_res [NCH];
  logic                 s2_vld;
  logic signed [DW-1:0] s2_sc  [NCH];
  mode_e                s2_mode;
  pol_e                 s2_pol;

  assign sc_in[0] = s1_in1;
  assign sc_in[1] = s1_in2d;

  for (genvar c = 0; c < NCH; c++) begin : g_scale
    fbk_scale #(.DW(DW), .SW(SW)) u_scale (
      .x_i (sc_in[c]),
      .f_i (s1_f[c]),
      .y_o (sc_res[c])
    );

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)     s2_sc[c] <= '0;
      else if (s1_vld) s2_sc[c] <= sc_res[c];
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      s2_vld  <= 1'b0;
      s2_mode <= MODE_SINGLE;
      s2_pol  <= POL_POS;
    end else begin
      s2_vld <= s1_vld;
      if (s1_vld) begin
        s2_mode <= s1_mode;
        s2_pol  <= s1_pol;
      end
    end
  end

  // stage 3: combine and saturate
  logic signed [DW-1:0] comb_res;

  fbk_combine #(.DW(DW)) u_combine (
    .mode_i (s2_mode),
    .pol_i  (s2_pol),
    .a_i    (s2_sc[0]),
    .b_i    (s2_sc[1]),
    .y_o    (comb_res)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_o <= 1'b0;
      out_o   <= '0;
    end else begin
      valid_o <= s2_vld;
      if (s2_vld) out_o <= comb_res;
    end
  end

  // peak magnitude tracking
  logic [DW-1:0] pk_mag [NPK];
  logic          pk_vld [NPK];
  logic [DW-1:0] pk_q   [NPK];
  logic [DW-1:0] sc_mag0, sc_mag1;

  assign sc_mag0   = mag_f(s2_sc[0]);
  assign sc_mag1   = mag_f(s2_sc[1]);
  assign pk_mag[0] = mag_f(s1_in1);
  assign pk_mag[1] = mag_f(s1_in2raw);
  assign pk_mag[2] = (sc_mag0 > sc_mag1) ? sc_mag0 : sc_mag1;
  assign pk_mag[3] = mag_f(out_o);
  assign pk_vld[0] = s1_vld;
  assign pk_vld[1] = s1_vld;
  assign pk_vld[2] = s2_vld;
  assign pk_vld[3] = valid_o;

  for (genvar p = 0; p < NPK; p++) begin : g_peak
    fbk_peak #(.DW(DW)) u_peak (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .clr_i  (clr_peaks_i),
      .vld_i  (pk_vld[p]),
      .mag_i  (pk_mag[p]),
      .pk_o   (pk_q[p])
    );
  end

  assign pk_in1_o   = pk_q[0];
  assign pk_in2_o   = pk_q[1];
  assign pk_scale_o = pk_q[2];
  assign pk_out_o   = pk_q[3];
endmodule

// File: rtl/fbk_datapath_chk.sv
`timescale 1ns/1ps
module fbk_datapath_chk #(
  parameter int DW = 12,
  parameter int AW = 8
) (
  input logic                 clk_i,
  input logic                 rst_ni,
  input logic                 valid_i,
  input logic        [DW-1:0] in2_i,
  input logic        [AW-1:0] delay_i,
  input logic                 clr_peaks_i,
  input logic                 valid_o,
  input logic signed [DW-1:0] out_o,
  input logic        [DW-1:0] pk_in1_o,
  input logic        [DW-1:0] pk_in2_o,
  input logic        [DW-1:0] pk_scale_o,
  input logic        [DW-1:0] pk_out_o,
  input logic                 s2_vld,
  input logic                 s2_dual,
  input logic                 s2_neg,
  input logic signed [DW-1:0] s2_sc0,
  input logic signed [DW-1:0] s2_sc1,
  input logic        [DW-1:0] s1_in2d
);
  localparam logic signed [DW-1:0] MINV = {1'b1, {(DW-1){1'b0}}};

  AST_LATENCY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i |-> ##3 valid_o); // R1

  AST_SINGLE_PASS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    s2_vld && !s2_dual && !s2_neg |=> out_o == $past(s2_sc0)); // R3

  AST_SINGLE_NEG: assert property (@(posedge clk_i) disable iff (!rst_ni)
    s2_vld && !s2_dual && s2_neg && s2_sc0 != MINV |=> out_o == -$past(s2_sc0)); // R4

  AST_NO_OVERFLOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    s2_vld && s2_dual && !s2_neg && !s2_sc0[DW-1] && !s2_sc1[DW-1] |=> !out_o[DW-1]); // R5

  AST_DELAY_BYPASS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i && delay_i == '0 |=> s1_in2d == $past(in2_i)); // R6

  AST_PEAK_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !clr_peaks_i |=> pk_out_o >= $past(pk_out_o) && pk_in1_o >= $past(pk_in1_o)); // R9

  AST_PEAK_CLEAR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_peaks_i |=> pk_in1_o == '0 && pk_in2_o == '0 && pk_scale_o == '0 && pk_out_o == '0); // R10
endmodule

bind fbk_datapath fbk_datapath_chk #(.DW(DW), .AW(AW)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .valid_i     (valid_i),
  .in2_i       (in2_i),
  .delay_i     (delay_i),
  .clr_peaks_i (clr_peaks_i),
  .valid_o     (valid_o),
  .out_o       (out_o),
  .pk_in1_o    (pk_in1_o),
  .pk_in2_o    (pk_in2_o),
  .pk_scale_o  (pk_scale_o),
  .pk_out_o    (pk_out_o),
  .s2_vld      (s2_vld),
  .s2_dual     (s2_mode == fbk_pkg::MODE_DUAL),
  .s2_neg      (s2_pol == fbk_pkg::POL_NEG),
  .s2_sc0      (s2_sc[0]),
  .s2_sc1      (s2_sc[1]),
  .s1_in2d     (s1_in2d)
);

// File: tb/fbk_datapath_test.sv
`timescale 1ns/1ps
module fbk_datapath_test;
  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic        valid_i = 1'b0;
  logic [11:0] in1_i = '0, in2_i = '0;
  logic        dual_mode_i = 1'b0, neg_fb_i = 1'b0;
  logic [4:0]  scale1_i = '0, scale2_i = '0;
  logic [7:0]  delay_i = '0;
  logic        clr_peaks_i = 1'b0;
  logic        valid_o;
  logic [11:0] out_o, pk_in1_o, pk_in2_o, pk_scale_o, pk_out_o;

  int checks = 0, errors = 0;
  int hist [0:16383];
  int nsamp = 0;
  int pm_in1 = 0, pm_in2 = 0, pm_sc = 0, pm_out = 0;

  always #2.5 clk = ~clk;

  fbk_datapath uut (
    .clk_i(clk), .rst_ni(rst_ni), .valid_i(valid_i), .in1_i(in1_i), .in2_i(in2_i),
    .dual_mode_i(dual_mode_i), .neg_fb_i(neg_fb_i), .scale1_i(scale1_i),
    .scale2_i(scale2_i), .delay_i(delay_i), .clr_peaks_i(clr_peaks_i),
    .valid_o(valid_o), .out_o(out_o), .pk_in1_o(pk_in1_o), .pk_in2_o(pk_in2_o),
    .pk_scale_o(pk_scale_o), .pk_out_o(pk_out_o)
  );

  function automatic int sat12(int v);
    if (v > 2047) return 2047;
    if (v < -2048) return -2048;
    return v;
  endfunction

  function automatic int scl(int x, int f);
    int p;
    p = x * f;
    return sat12(p >>> 4);
  endfunction

  function automatic int iabs(int v);
    return (v < 0) ? -v : v;
  endfunction

  function automatic int sx(logic [11:0] v);
    return int'($signed(v));
  endfunction

  task automatic chk(bit ok, string req, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic send(int a, int b, bit dual, bit neg, int f1, int f2, int d, string tag);
    int bd, s1, s2, ex;
    @(negedge clk);
    in1_i = a[11:0]; in2_i = b[11:0];
    dual_mode_i = dual; neg_fb_i = neg;
    scale1_i = f1[4:0]; scale2_i = f2[4:0]; delay_i = d[7:0];
    valid_i = 1'b1;
    bd = (d == 0) ? b : ((nsamp >= d) ? hist[nsamp - d] : 0);
    hist[nsamp] = b;
    nsamp++;
    s1 = scl(a, f1);
    s2 = scl(bd, f2);
    if (dual) ex = neg ? sat12(s1 - s2) : sat12(s1 + s2);
    else      ex = neg ? sat12(-s1) : s1;
    if (iabs(a) > pm_in1) pm_in1 = iabs(a);
    if (iabs(b) > pm_in2) pm_in2 = iabs(b);
    if (iabs(s1) > pm_sc) pm_sc = iabs(s1);
    if (iabs(s2) > pm_sc) pm_sc = iabs(s2);
    if (iabs(ex) > pm_out) pm_out = iabs(ex);
    @(negedge clk);
    valid_i = 1'b0;
    // R7: disturb config while sample is in flight
    dual_mode_i = ~dual; neg_fb_i = ~neg;
    scale1_i = ~scale1_i; scale2_i = ~scale2_i; delay_i = delay_i + 8'd7;
    @(negedge clk);
    chk(valid_o == 1'b0, "R1 early", int'(valid_o), 0);
    @(negedge clk);
    chk(valid_o == 1'b1, "R1 latency", int'(valid_o), 1);
    chk(sx(out_o) == ex, tag, sx(out_o), ex);
  endtask

  task automatic chk_peaks(string tag);
    chk(int'(pk_in1_o) == pm_in1, tag, int'(pk_in1_o), pm_in1);
    chk(int'(pk_in2_o) == pm_in2, tag, int'(pk_in2_o), pm_in2);
    chk(int'(pk_scale_o) == pm_sc, tag, int'(pk_scale_o), pm_sc);
    chk(int'(pk_out_o) == pm_out, tag, int'(pk_out_o), pm_out);
  endtask

  task automatic clear_model();
    pm_in1 = 0; pm_in2 = 0; pm_sc = 0; pm_out = 0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual %0d expected %0d", 200000, 0);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    int vals [7] = '{-2048, -1, 0, 1, 1000, 2047, -777};
    int fl [6]   = '{0, 1, 15, 16, 17, 31};
    int dl [4]   = '{0, 1, 3, 255};
    int idx;

    // R11 reset state
    repeat (3) @(negedge clk);
    chk(valid_o == 1'b0 && out_o == '0, "R11 reset out", sx(out_o), 0);
    chk(pk_in1_o == '0 && pk_out_o == '0, "R11 reset peaks", int'(pk_out_o), 0);
    rst_ni = 1'b1;

    // R2 scaling sweep, single positive mode
    for (int f = 0; f < 32; f++) begin
      send(2047, 0, 0, 0, f, 0, 0, "R2 scale max");
      send(-2048, 0, 0, 0, f, 0, 0, "R2 scale min");
      send(-1, 0, 0, 0, f, 0, 0, "R2 scale floor");
      send(5, 0, 0, 0, f, 0, 0, "R2 scale small");
    end

    // R9 peaks with small values after a clear
    @(negedge clk); clr_peaks_i = 1'b1;
    @(negedge clk); clr_peaks_i = 1'b0;
    clear_model();
    send(-300, 100, 1, 0, 16, 8, 0, "R5 peak setup");
    send(40, -250, 1, 1, 24, 16, 0, "R5 peak setup");
    @(negedge clk);
    chk_peaks("R9 peaks");

    // R10 clear collides with output-peak update
    send(-700, 9, 0, 1, 16, 16, 0, "R4 pre clear");
    clr_peaks_i = 1'b1;
    @(negedge clk); clr_peaks_i = 1'b0;
    clear_model();
    chk_peaks("R10 clear");

    // R8 delay change applies to next sample
    send(0, 100, 1, 0, 0, 16, 1, "R6 seq");
    send(0, 200, 1, 0, 0, 16, 1, "R6 seq");
    send(0, 300, 1, 0, 0, 16, 1, "R6 seq");
    send(0, 400, 1, 0, 0, 16, 3, "R8 delay change");
    send(0, 500, 1, 0, 0, 16, 0, "R8 delay zero");

    // main sweep: modes, polarity, factors, inputs, delays
    idx = 0;
    for (int m = 0; m < 2; m++)
      for (int ng = 0; ng < 2; ng++)
        for (int i1 = 0; i1 < 6; i1++)
          for (int i2 = 0; i2 < 6; i2++)
            for (int a = 0; a < 7; a++)
              for (int b = 0; b < 7; b++) begin
                send(vals[a], vals[(b + idx) % 7], m[0], ng[0], fl[i1], fl[i2], dl[idx % 4],
                     m ? "R5 R6 R7 dual" : (ng ? "R4 R7 single neg" : "R3 R7 single pos"));
                idx++;
              end
    @(negedge clk);
    chk_peaks("R9 sweep peaks");

    // R11 mid-run reset: history reads zero
    @(negedge clk); rst_ni = 1'b0;
    @(negedge clk);
    chk(pk_out_o == '0 && valid_o == 1'b0, "R11 mid reset", int'(pk_out_o), 0);
    rst_ni = 1'b1;
    nsamp = 0;
    clear_model();
    for (int k = 0; k < 6; k++)
      send(0, 600 + k, 1, 0, 0, 16, 3, "R11 cleared history");

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule